// File: doc/BRIEF.md
# Interrupt Pin Dispatcher

The dispatcher watches a bank of external interrupt inputs, folds them onto a set of interrupt pins and keeps one pending bit per pin. A rotating pointer visits one pin per cycle. For the visited pin it reads that pin's routing entry (vector, delivery mode, destination field, destination mode) through a read port. It turns a pending, unmasked request into a message write: a 32-bit address and a 32-bit data word, presented on a valid/ready output.

The mask, trigger mode and remote-IRR flag of every pin come in as flat vectors from the register file that owns the routing table. When a level-triggered pin is delivered, the dispatcher asks that register file to set the pin's remote-IRR flag. While the flag is set, the pin is not delivered again. The end-of-interrupt path clears the flag elsewhere, and delivery then resumes if the input is still asserted.

Top module: `irq_dispatch`

## Requirements
- R1: After reset no message is valid, no remote-IRR set request is raised and every pending bit is clear.
- R2: Pin 2 is requested by the OR of input 0 and input 2. Pin 0 is never requested. Input k drives pin k for every other k below the pin count. Inputs at or above the pin count have no effect.
- R3: A pin whose `pin_level` bit is 1 is pending exactly while its mapped input is high. When it is visited unmasked with its remote-IRR flag clear, one message is issued.
- R4: When a level pin is delivered, the one-hot `rirr_set` bit for that pin is raised in the same cycle the message is loaded. While its remote-IRR flag is set, the pin issues no message and raises no set request. Its pending bit is kept, so it delivers again once the flag clears with the input still high.
- R5: A pin whose `pin_level` bit is 0 becomes pending on a rising edge of its mapped input only if the pin is unmasked at that edge. A rising edge seen while masked is lost, even after the pin is unmasked.
- R6: Delivering an edge pin clears its pending bit, so each accepted rising edge yields exactly one message.
- R7: A masked pin issues no message and keeps its pending bit. A level pin held high while masked delivers after it is unmasked.
- R8: Data word: bits 7:0 the vector, bits 10:8 the delivery mode, bit 15 the trigger mode (1 = level). All other bits are 0.
- R9: Address word: the base 0xFEE00000 ORed with the 16-bit destination field at bits 19:4 and the destination-mode bit at bit 2.
- R10: Pins are visited in ascending index order, wrapping from the last pin to pin 0. At most one message is loaded per cycle.
- R11: While `msg_valid` is high and `msg_ready` is low, the address, data and valid stay unchanged, and the pointer does not advance.
- R12: When the delivery mode is 3'b111, the data word's vector is taken from `ext_vector` instead of the routing entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_INPUTS | External interrupt input levels |
| pin_mask | input | NUM_PINS | Per-pin mask bits |
| pin_level | input | NUM_PINS | Per-pin trigger mode, 1 = level |
| pin_rirr | input | NUM_PINS | Per-pin remote-IRR flags |
| rd_pin | output | $clog2(NUM_PINS) | Index of the pin whose entry is read |
| rd_vector | input | 8 | Vector of the entry at `rd_pin` |
| rd_dlv | input | 3 | Delivery mode of the entry at `rd_pin` |
| rd_dmode | input | 1 | Destination mode of the entry at `rd_pin` |
| rd_dest | input | 16 | Destination field of the entry at `rd_pin` |
| ext_vector | input | 8 | Vector used when the delivery mode is 3'b111 |
| rirr_set | output | NUM_PINS | One-hot request to set a pin's remote-IRR flag |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the downstream side |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A stale or wrong pending bit shows up within one full pointer revolution, at most NUM_PINS cycles. It appears as a missing message, a duplicate message for an edge pin, or a spurious `rirr_set` pulse. A corrupted pointer or a pointer that moves during a stall shows up in the next loaded message as the wrong address/data pair or as a change while stalled. The reference model predicts the valid, address, data and set-request outputs for every cycle, so any of these differences is reported in the cycle it first reaches the ports.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int          NUM_PINS   = 24,
  parameter int          NUM_INPUTS = 32,
  parameter logic [31:0] ADDR_BASE  = 32'hFEE0_0000,
  parameter logic [2:0]  EXT_MODE   = 3'b111,
  localparam int         PW         = $clog2(NUM_PINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INPUTS-1:0] irq_in,
  input  logic [NUM_PINS-1:0]   pin_mask,
  input  logic [NUM_PINS-1:0]   pin_level,
  input  logic [NUM_PINS-1:0]   pin_rirr,
  output logic [PW-1:0]         rd_pin,
  input  logic [7:0]            rd_vector,
  input  logic [2:0]            rd_dlv,
  input  logic                  rd_dmode,
  input  logic [15:0]           rd_dest,
  input  logic [7:0]            ext_vector,
  output logic [NUM_PINS-1:0]   rirr_set,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [31:0]           msg_addr,
  output logic [31:0]           msg_data
);

  logic [NUM_PINS-1:0] req_now, req_q, pend, pend_nx, sel, clr;
  logic [PW-1:0]       ptr;
  logic                out_free, cand, fire;
  logic [7:0]          vec;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    if (p == 0) begin : g_zero
      assign req_now[p] = 1'b0;
    end else if (p == 2) begin : g_remap
      assign req_now[p] = irq_in[0] | irq_in[2];
    end else if (p < NUM_INPUTS) begin : g_direct
      assign req_now[p] = irq_in[p];
    end else begin : g_none
      assign req_now[p] = 1'b0;
    end
  end

  assign rd_pin   = ptr;
  assign out_free = !msg_valid || msg_ready;
  assign sel      = NUM_PINS'(1) << ptr;
  assign cand     = out_free && pend[ptr] && !pin_mask[ptr];
  assign fire     = cand && (!pin_level[ptr] || !pin_rirr[ptr]);
  assign rirr_set = (cand && pin_level[ptr] && !pin_rirr[ptr]) ? sel : '0;
  assign clr      = (fire && !pin_level[ptr]) ? sel : '0;
  assign vec      = (rd_dlv == EXT_MODE) ? ext_vector : rd_vector;

  assign pend_nx = (pin_level & req_now)
                 | (~pin_level & ((pend & ~clr) | (req_now & ~req_q & ~pin_mask)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
      ptr   <= '0;
    end else begin
      req_q <= req_now;
      pend  <= pend_nx;
      if (out_free) ptr <= (ptr == PW'(NUM_PINS - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (fire) begin
      msg_valid <= 1'b1;
      msg_addr  <= ADDR_BASE | {12'h000, rd_dest, 1'b0, rd_dmode, 2'b00};
      msg_data  <= {16'h0000, pin_level[ptr], 4'h0, rd_dlv, vec};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_dispatch_sva.sv
module irq_dispatch_sva #(
  parameter int          NUM_PINS  = 24,
  parameter logic [31:0] ADDR_BASE = 32'hFEE0_0000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_mask,
  input logic [NUM_PINS-1:0] pin_level,
  input logic [NUM_PINS-1:0] pin_rirr,
  input logic [NUM_PINS-1:0] rirr_set,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [31:0]         msg_addr,
  input logic [31:0]         msg_data
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R11

  AST_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rirr_set)); // R10

  AST_SET_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    |rirr_set |-> (rirr_set & (~pin_level | pin_rirr | pin_mask)) == '0); // R4

  AST_SET_GIVES_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    |rirr_set |=> msg_valid); // R3

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[31:20] == ADDR_BASE[31:20]) && !msg_addr[3] && (msg_addr[1:0] == 2'b00)); // R9

  AST_DATA_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == 16'h0) && (msg_data[14:11] == 4'h0)); // R8

  AST_PIN0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rirr_set[0]); // R2

endmodule

bind irq_dispatch irq_dispatch_sva #(.NUM_PINS(NUM_PINS), .ADDR_BASE(ADDR_BASE)) sva_i (
  .clk(clk), .rst_n(rst_n), .pin_mask(pin_mask), .pin_level(pin_level),
  .pin_rirr(pin_rirr), .rirr_set(rirr_set), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

// File: tb/irq_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_dispatch_tb_top;
  localparam int NP = 24;
  localparam int NI = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NI-1:0] irq = '0;
  logic [NP-1:0] mask = '0, lvl = '0, rirr = '0, rirr_clr = '0;
  logic [7:0]  vec  [NP];
  logic [2:0]  dlv  [NP];
  logic        dm   [NP];
  logic [15:0] dest [NP];
  logic [7:0]  ext_vec = 8'h99;
  logic        ready = 1'b1;

  logic [4:0]    rd_pin;
  logic [NP-1:0] rirr_set;
  logic          msg_valid;
  logic [31:0]   msg_addr, msg_data;

  irq_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .pin_mask(mask), .pin_level(lvl),
    .pin_rirr(rirr), .rd_pin(rd_pin), .rd_vector(vec[rd_pin]), .rd_dlv(dlv[rd_pin]),
    .rd_dmode(dm[rd_pin]), .rd_dest(dest[rd_pin]), .ext_vector(ext_vec),
    .rirr_set(rirr_set), .msg_valid(msg_valid), .msg_ready(ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  always @(posedge clk) rirr <= (rirr | rirr_set) & ~rirr_clr;

  int nchk = 0, nfail = 0, cycles = 0;
  string cur = "R1";
  logic [31:0] got_addr [$];
  logic [31:0] got_data [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  int m_pend [NP];
  int m_q [NP];
  int m_ptr;
  bit m_valid;
  logic [31:0] m_addr, m_data;

  always @(negedge clk) begin
    #2;
    cycles++;
    if (cycles > 20000) begin
      chk(0, "watchdog", cycles, 20000);
      report();
    end
    if (!rst_n) begin
      foreach (m_pend[q]) begin m_pend[q] = 0; m_q[q] = 0; end
      m_ptr = 0; m_valid = 0; m_addr = '0; m_data = '0;
    end else begin
      int p;
      bit free, cand, fire;
      logic [NP-1:0] exp_set;
      logic [7:0] v;
      p = m_ptr;
      free = !m_valid || ready;
      cand = free && (m_pend[p] != 0) && !mask[p];
      fire = cand && (!lvl[p] || !rirr[p]);
      exp_set = (cand && lvl[p] && !rirr[p]) ? (NP'(1) << p) : '0;
      chk(msg_valid === m_valid, {cur, " valid"}, 32'(msg_valid), 32'(m_valid));
      if (m_valid) begin
        chk(msg_addr === m_addr, {cur, " addr"}, msg_addr, m_addr);
        chk(msg_data === m_data, {cur, " data"}, msg_data, m_data);
      end
      chk(rirr_set === exp_set, {cur, " rirr_set"}, 32'(rirr_set), 32'(exp_set));
      if (msg_valid && ready) begin
        got_addr.push_back(msg_addr);
        got_data.push_back(msg_data);
      end
      for (int q = 0; q < NP; q++) begin
        int rq, np;
        rq = (q == 0) ? 0 : (q == 2) ? int'(irq[0] | irq[2]) : int'(irq[q]);
        if (lvl[q]) np = rq;
        else begin
          np = m_pend[q];
          if (fire && q == p) np = 0;
          if (rq != 0 && m_q[q] == 0 && !mask[q]) np = 1;
        end
        m_q[q] = rq;
        m_pend[q] = np;
      end
      if (fire) begin
        m_valid = 1;
        m_addr = 32'hFEE0_0000 | (32'(dest[p]) << 4) | (32'(dm[p]) << 2);
        v = (dlv[p] == 3'b111) ? ext_vec : vec[p];
        m_data = 32'(v) | (32'(dlv[p]) << 8) | (32'(lvl[p]) << 15);
      end else if (ready) m_valid = 0;
      if (free) m_ptr = (p == NP - 1) ? 0 : p + 1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq[i] = 1'b1;
    @(negedge clk); irq[i] = 1'b0;
  endtask

  task automatic clear_rirr(input int i);
    @(negedge clk); rirr_clr[i] = 1'b1;
    @(negedge clk); rirr_clr[i] = 1'b0;
  endtask

  task automatic expect_count(input int n, input string req);
    chk(got_data.size() == n, req, got_data.size(), n);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      vec[i] = 8'h20 + 8'(i); dlv[i] = 3'd0; dm[i] = 1'b0; dest[i] = 16'(i);
    end
    dest[5] = 16'hABCD; dm[5] = 1'b1;
    dlv[8] = 3'd1;
    dlv[10] = 3'b111;
    idle(3);
    cur = "R1";
    chk(msg_valid === 1'b0, "R1 valid in reset", 32'(msg_valid), 0);
    chk(rirr_set === '0, "R1 rirr_set in reset", 32'(rirr_set), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(30);
    expect_count(0, "R1 no message after reset");

    cur = "R6";
    got_addr.delete(); got_data.delete();
    pulse(5);
    idle(60);
    expect_count(1, "R6 one message per edge");
    if (got_data.size() > 0) begin
      chk(got_addr[0] == 32'hFEEA_BCD4, "R9 address form", got_addr[0], 32'hFEEA_BCD4);
      chk(got_data[0] == 32'h0000_0025, "R8 edge data form", got_data[0], 32'h25);
    end

    cur = "R5";
    got_data.delete();
    mask[6] = 1'b1;
    pulse(6);
    idle(30);
    @(negedge clk); mask[6] = 1'b0;
    idle(40);
    expect_count(0, "R5 masked edge dropped");

    cur = "R2";
    got_data.delete();
    pulse(0);
    idle(40);
    expect_count(1, "R2 input 0 to pin 2");
    if (got_data.size() > 0)
      chk(got_data[0][7:0] == 8'h22, "R2 pin 2 vector", 32'(got_data[0][7:0]), 32'h22);
    got_data.delete();
    pulse(30);
    idle(40);
    expect_count(0, "R2 input above pin count ignored");

    cur = "R4";
    got_data.delete();
    @(negedge clk); lvl[8] = 1'b1; irq[8] = 1'b1;
    idle(80);
    expect_count(1, "R4 remote flag blocks repeat");
    if (got_data.size() > 0)
      chk(got_data[0] == 32'h0000_8128, "R8 level data form", got_data[0], 32'h8128);
    chk(rirr[8] === 1'b1, "R4 remote flag set", 32'(rirr[8]), 1);
    cur = "R3";
    clear_rirr(8);
    idle(40);
    expect_count(2, "R3 redelivery after flag clears");
    @(negedge clk); irq[8] = 1'b0;
    idle(2);
    clear_rirr(8);
    idle(40);
    expect_count(2, "R3 deasserted level not pending");

    cur = "R7";
    got_data.delete();
    @(negedge clk); lvl[9] = 1'b1; mask[9] = 1'b1; irq[9] = 1'b1;
    idle(50);
    expect_count(0, "R7 masked pin silent");
    @(negedge clk); mask[9] = 1'b0;
    idle(40);
    expect_count(1, "R7 pending kept through mask");
    @(negedge clk); irq[9] = 1'b0;
    idle(2);
    clear_rirr(9);

    cur = "R12";
    got_data.delete();
    pulse(10);
    idle(40);
    expect_count(1, "R12 ext vector message");
    if (got_data.size() > 0)
      chk(got_data[0] == 32'h0000_0799, "R12 ext vector data", got_data[0], 32'h799);

    cur = "R11";
    got_data.delete();
    @(negedge clk); ready = 1'b0; irq[11] = 1'b1; irq[12] = 1'b1; irq[13] = 1'b1;
    @(negedge clk); irq[11] = 1'b0; irq[12] = 1'b0; irq[13] = 1'b0;
    idle(40);
    chk(msg_valid === 1'b1, "R11 held while stalled", 32'(msg_valid), 1);
    @(negedge clk); ready = 1'b1;
    idle(40);
    expect_count(3, "R11 all stalled messages drain");
    if (got_data.size() == 3)
      chk(got_data[0][7:0] + got_data[1][7:0] + got_data[2][7:0] == 9'h84 - 9'h0,
          "R11 drained vectors", 32'(got_data[0][7:0] + got_data[1][7:0] + got_data[2][7:0]), 32'h84);

    cur = "R10";
    got_data.delete();
    @(negedge clk); irq[14] = 1'b1; irq[16] = 1'b1; irq[18] = 1'b1;
    @(negedge clk); irq[14] = 1'b0; irq[16] = 1'b0; irq[18] = 1'b0;
    idle(40);
    expect_count(3, "R10 three pins delivered");

    report();
  end
endmodule